// File: doc/BRIEF.md
# Overlapping 1011 Serial Pattern Detector

This block samples a one-bit serial stream on every rising clock edge and raises a flag in each cycle where the bits received so far end in 1, 0, 1, 1. Matches may share bits, so the last two bits of one match can start the next one. The flag is a Mealy output. It is formed from the registered progress state and the bit now on the input. It rises in the same cycle as the final 1 and does not wait for the next edge.

The progress state is two bits. The high bit sits in a JK flip-flop and the low bit sits in a D flip-flop. Each flip-flop is fed by its own excitation equation. The state encoding is 00 for no progress, 01 after a 1, 10 after 1,0 and 11 after 1,0,1. The low bit always holds the previous input bit. The JK cell holds on J=0,K=0, clears on J=0,K=1, sets on J=1,K=0 and toggles on J=1,K=1.

Top module: `serial_match_1011`

## Requirements
- R1: While rst_n is low at a rising edge the state returns to 00. After such an edge, a 1 on din gives hit = 0.
- R2: hit is 1 exactly when the three bits sampled at the edges since the last reset, oldest first, are 1, 0, 1 and din is currently 1.
- R3: Overlapping matches count. After a reset, the stream 1,0,1,1,0,1,1 gives hit = 1 on the 4th and 7th bits and 0 on the others.
- R4: hit follows din in the same cycle without a clock edge. After 1,0,1, hit is 0 while din = 0 and 1 while din = 1.
- R5: A 0 that follows 1,0 discards all progress. After a reset, the stream 1,0,0,1,1 never raises hit.
- R6: A 0 that follows 1,0,1 keeps 1,0 as progress. After a reset, the stream 1,0,1,0,1,1 raises hit only on its last bit.
- R7: A run of 1s keeps only a single 1 as progress. After a reset, 1,1,1,1 never raises hit, and a following 0,1,1 raises hit on its last bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 1 | Serial data bit, sampled each edge |
| hit | output | 1 | Mealy match flag for the current bit |

## Verification
The hardest case is a return to 1,0 progress after a broken 1,0,1 (1,0,1,0). The reverse case, a 0 after 1,0 that empties the state, only shows at the ports through whether a match comes later. Both are reached only by streams whose failure or success appears several bits after the bit that caused it. The vector table and the directed runs place these prefixes in front of a completing 1,1 or a non-completing 1. A long random stream, compared on every cycle against a shift-register model of the last three bits, covers the remaining paths, including resets in the middle of a pattern.

// File: rtl/serial_match_pkg.sv
// Package: shared state encoding for the 1011 serial detector.
// Assumes a two-bit state: high bit = JK cell, low bit = D cell.
package serial_match_pkg;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        PROG_NONE   = 2'b00,
        PROG_1      = 2'b01,
        PROG_10     = 2'b10,
        PROG_101    = 2'b11
    } prog_state_e;
endpackage

// File: rtl/sm_jk_cell.sv
// Module: JK flip-flop model with synchronous active-low reset.
// Assumes single clock; 00 hold, 01 clear, 10 set, 11 toggle.
module sm_jk_cell #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic j,
    input  logic k,
    output logic q
);
    // Purpose: apply JK excitation at each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else begin
            unique case ({j, k})
                2'b00:   q <= q;
                2'b01:   q <= 1'b0;
                2'b10:   q <= 1'b1;
                default: q <= ~q;
            endcase
        end
    end
endmodule

// File: rtl/sm_d_cell.sv
// Module: D flip-flop model with synchronous active-low reset.
// Assumes single clock domain.
module sm_d_cell #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    // Purpose: capture d at each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= d;
    end
endmodule

// File: rtl/sm_excite.sv
// Module: excitation and output equations for the 1011 detector.
// Assumes state encoding from serial_match_pkg (hi = JK bit, lo = D bit).
module sm_excite (
    input  logic q_hi,
    input  logic q_lo,
    input  logic din,
    output logic j_hi,
    output logic k_hi,
    output logic d_lo,
    output logic hit
);
    // Purpose: derive flip-flop inputs and the Mealy flag.
    always_comb begin
        j_hi = q_lo & ~din;
        k_hi = (q_lo & din) | (~q_lo & ~din);
        d_lo = din;
        hit  = q_hi & q_lo & din;
    end
endmodule

// File: rtl/serial_match_1011.sv
// Module: overlapping 1011 serial detector, Mealy output.
// Assumes din is synchronous to clk; reset is synchronous, active low.
module serial_match_1011 (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic hit
);
    import serial_match_pkg::*;

    logic q_hi, q_lo;
    logic j_hi, k_hi, d_lo;

    sm_excite u_excite (
        .q_hi (q_hi),
        .q_lo (q_lo),
        .din  (din),
        .j_hi (j_hi),
        .k_hi (k_hi),
        .d_lo (d_lo),
        .hit  (hit)
    );

    sm_jk_cell #(.RESET_VAL(PROG_NONE[1])) u_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .j     (j_hi),
        .k     (k_hi),
        .q     (q_hi)
    );

    sm_d_cell #(.RESET_VAL(PROG_NONE[0])) u_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (d_lo),
        .q     (q_lo)
    );
endmodule

// File: rtl/serial_match_chk.sv
// Module: assertion checker bound to serial_match_1011.
// Assumes access to the two state bits through the bind.
module serial_match_chk (
    input logic clk,
    input logic rst_n,
    input logic x,
    input logic y,
    input logic a,
    input logic b
);
    logic [2:0] hist;
    logic [1:0] depth;

    // Purpose: track last three bits and how many are valid since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist  <= 3'b000;
            depth <= 2'd0;
        end else begin
            hist  <= {hist[1:0], x};
            depth <= (depth == 2'd3) ? depth : depth + 2'd1;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!a && !b));

    assert_match_seen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (depth == 2'd3 && hist == 3'b101 && x) |-> y);

    assert_no_false_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(depth == 2'd3 && hist == 3'b101 && x) |-> !y);

    assert_overlap_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        y |=> (!a && b));

    assert_flag_needs_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        y |-> x);

    assert_drop_after_100_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (a && !b && !x) |=> (!a && !b));

    assert_keep_10_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (a && b && !x) |=> (a && !b));

    assert_ones_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!a && b && x) |=> (!a && b));
endmodule

bind serial_match_1011 serial_match_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .x     (din),
    .y     (hit),
    .a     (q_hi),
    .b     (q_lo)
);

// File: tb/tb_serial_match_1011.sv
// Bench: vector table, directed cases, then random stream vs. reference.
module tb_serial_match_1011;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic hit;

    int checks = 0;
    int errors = 0;

    serial_match_1011 dut (.clk(clk), .rst_n(rst_n), .din(din), .hit(hit));

    always #2 clk = ~clk;

    // Reference: last three bits since reset, and their count.
    logic [2:0] ref_hist = 3'b000;
    int         ref_cnt  = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            ref_hist <= 3'b000;
            ref_cnt  <= 0;
        end else begin
            ref_hist <= {ref_hist[1:0], din};
            ref_cnt  <= (ref_cnt < 3) ? ref_cnt + 1 : 3;
        end
    end

    function automatic logic ref_hit(input logic xb);
        return (ref_cnt >= 3) && (ref_hist == 3'b101) && xb;
    endfunction

    task automatic check(input logic exp, input string tag);
        checks++;
        if (hit !== exp) begin
            errors++;
            $display("FAIL %s: hit=%b expected=%b at %0t", tag, hit, exp, $time);
        end
    endtask

    // Drive one bit away from the edge, then check the Mealy flag.
    task automatic step(input logic xb, input logic exp, input string tag);
        @(negedge clk);
        din = xb;
        #1;
        check(exp, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        din   = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Table entries: {din, expected hit}.
    localparam int NV = 21;
    localparam logic [1:0] VEC [NV] = '{
        2'b10, 2'b00, 2'b10, 2'b11, 2'b00, 2'b10, 2'b11,
        2'b00, 2'b00, 2'b10, 2'b00, 2'b10, 2'b11, 2'b10,
        2'b10, 2'b10, 2'b00, 2'b10, 2'b00, 2'b10, 2'b11
    };

    initial begin : watchdog
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        // R1: reset state, din=1 must not flag.
        repeat (2) @(posedge clk);
        @(negedge clk);
        din = 1'b1;
        #1;
        check(1'b0, "R1 in reset");
        rst_n = 1'b1;
        #1;
        check(1'b0, "R1 after reset");
        do_reset();

        // R2/R3: table walk, cross-checked with the reference model.
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][1], VEC[i][0], "R2 table");
            check(ref_hit(VEC[i][1]), "R3 table vs ref");
        end

        // R3: overlapping pair.
        do_reset();
        step(1, 0, "R3"); step(0, 0, "R3"); step(1, 0, "R3"); step(1, 1, "R3");
        step(0, 0, "R3"); step(1, 0, "R3"); step(1, 1, "R3");

        // R4: flag follows din within one cycle.
        do_reset();
        step(1, 0, "R4"); step(0, 0, "R4"); step(1, 0, "R4");
        @(negedge clk);
        din = 1'b0; #1; check(1'b0, "R4 din low");
        din = 1'b1; #1; check(1'b1, "R4 din high");

        // R5: 100 clears progress.
        do_reset();
        step(1, 0, "R5"); step(0, 0, "R5"); step(0, 0, "R5");
        step(1, 0, "R5"); step(1, 0, "R5");

        // R6: 1010 keeps 10.
        do_reset();
        step(1, 0, "R6"); step(0, 0, "R6"); step(1, 0, "R6");
        step(0, 0, "R6"); step(1, 0, "R6"); step(1, 1, "R6");

        // R7: run of ones holds a single 1.
        do_reset();
        step(1, 0, "R7"); step(1, 0, "R7"); step(1, 0, "R7"); step(1, 0, "R7");
        step(0, 0, "R7"); step(1, 0, "R7"); step(1, 1, "R7");

        // R1: reset mid-pattern discards 101.
        do_reset();
        step(1, 0, "R1"); step(0, 0, "R1"); step(1, 0, "R1");
        do_reset();
        step(1, 0, "R1 after mid reset");

        // R2: random stream with occasional resets.
        for (int n = 0; n < 3000; n++) begin
            logic xb;
            xb = 1'($urandom_range(0, 1));
            @(negedge clk);
            rst_n = ($urandom_range(0, 99) != 0);
            din   = xb;
            #1;
            check(ref_hit(xb), "R2 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule